// File: doc/BRIEF.md
# SWD Line-Reset Connect Sequencer

This block is the host-side helper that brings a debug target's two-wire port out of JTAG operation and into Serial Wire Debug, and leaves the line in a freshly reset state. A single-cycle `start` pulse begins the sequence. The block then generates the clock line and drives the data line through a fixed bit stream with 152 bits. The stream has four parts, in order: 64 ones, the 16-bit selection code 0xE79E sent least significant bit first, another 64 ones, and 8 idle zeros.

The length of each half of the clock period is set in system clocks by `div_half`, which is sampled when the sequence starts. The data line changes only when the clock falls, so the target sees a stable value at every rising edge. When the last idle bit completes, the clock is parked high, the data driver is released, and `done` pulses for one cycle. A transaction engine can then issue the first identification read. The full sequence runs every time. It does not check whether the target is already in serial mode, because the identification read that follows is what enables the link.

Top module: `swd_line_reset_seq`

## Requirements
- R1: After reset the block is idle: `swclk`=1, `swdio_oe`=0, `swdio_o`=0, `busy`=0, `done`=0.
- R2: A `start` seen while idle is accepted on that clock edge. In the following cycle `busy`=1, `swclk`=0 and `swdio_oe`=1.
- R3: Bits 0 to 63 of the stream (bit k is the value of `swdio_o` at the k-th rising edge of `swclk`) are all 1.
- R4: Bits 64 to 79 are the 16-bit code 0xE79E sent least significant bit first: bit 64+n equals code bit n, so bit 64 is 0 and bit 65 is 1.
- R5: Bits 80 to 143 are all 1.
- R6: Bits 144 to 151 are all 0, and the stream has exactly 152 bits.
- R7: While `swdio_oe`=1, `swdio_o` changes only in the cycle where `swclk` falls. It is stable while `swclk` is high and across every rising edge.
- R8: Each low half and each high half of `swclk` lasts H system clocks, where H is `div_half` sampled at the accepting edge, or 1 when that value is 0. Changes to `div_half` during a run have no effect, and `busy` stays high for exactly 304·H cycles.
- R9: After the last bit's high half, `swclk` stays 1 and `swdio_oe` goes to 0. `busy` falls, and `done` is 1 for exactly one cycle, in the same cycle that `busy` first reads 0.
- R10: `start` while `busy` is ignored: the run in progress keeps its 152 bits and its length.
- R11: Every accepted `start` produces the same complete sequence, including when runs follow one another directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a connect sequence (ignored while busy) |
| div_half | input | DIV_W | Half-period of the serial clock in system clocks (0 acts as 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence finishes |
| swclk | output | 1 | Serial debug clock to the target |
| swdio_o | output | 1 | Serial debug data driven toward the target |
| swdio_oe | output | 1 | Output enable for the data driver |

## Verification
The embedded assertions check several rules on every cycle. The data line holds its value whenever the clock is high. A released driver implies a parked-high clock. `done` is a single pulse that marks the fall of `busy`. The half-period counter stays below its limit, and the bit index never steps past the last bit. Only the bench scenarios can show the content of the stream: the four segments, the LSB-first order of the selection code and the total of 152 bits. The same holds for the exact half-period length for several divider values, for a divider change or a repeated `start` during a run having no effect, and for back-to-back runs producing identical streams.

// File: rtl/swdlr_pkg.sv
package swdlr_pkg;

    localparam int          LEAD_ONES   = 64;
    localparam int          CODE_BITS   = 16;
    localparam logic [15:0] SELECT_WORD = 16'hE79E;
    localparam int          TRAIL_ONES  = 64;
    localparam int          IDLE_ZEROS  = 8;
    localparam int          SEQ_BITS    = LEAD_ONES + CODE_BITS + TRAIL_ONES + IDLE_ZEROS;
    localparam int          IDX_W       = $clog2(SEQ_BITS);

    typedef enum logic [1:0] {
        SEG_LEAD,
        SEG_CODE,
        SEG_TRAIL,
        SEG_IDLE
    } seg_e;

    typedef struct packed {
        logic clk_line;
        logic data;
        logic data_en;
    } pins_t;

    localparam pins_t PINS_PARKED = '{clk_line: 1'b1, data: 1'b0, data_en: 1'b0};

    function automatic seg_e seg_of(input int unsigned idx);
        if (idx < LEAD_ONES)                              return SEG_LEAD;
        else if (idx < LEAD_ONES + CODE_BITS)             return SEG_CODE;
        else if (idx < LEAD_ONES + CODE_BITS + TRAIL_ONES) return SEG_TRAIL;
        else                                              return SEG_IDLE;
    endfunction

    function automatic logic bit_at(input int unsigned idx);
        int unsigned off;
        off = idx - LEAD_ONES;
        case (seg_of(idx))
            SEG_LEAD:  return 1'b1;
            SEG_CODE:  return SELECT_WORD[off[3:0]];
            SEG_TRAIL: return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/swdlr_half_timer.sv
module swdlr_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            if (tick) cnt_q <= '0;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (run && limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/swdlr_bit_source.sv
module swdlr_bit_source
    import swdlr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic advance,
    output logic first_bit,
    output logic next_bit,
    output logic is_last
);

    logic [IDX_W-1:0] idx_q;

    assign first_bit = bit_at(0);
    assign next_bit  = bit_at(int'(idx_q) + 1);
    assign is_last   = (int'(idx_q) == SEQ_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst || load)  idx_q <= '0;
        else if (advance) idx_q <= idx_q + 1'b1;
    end

    // R6
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) <= SEQ_BITS - 1);

    // R10
    no_step_past_end_chk: assert property (@(posedge clk) disable iff (rst)
        advance |-> !is_last);

endmodule

// File: rtl/swd_line_reset_seq.sv
module swd_line_reset_seq
    import swdlr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div_half,
    output logic             busy,
    output logic             done,
    output logic             swclk,
    output logic             swdio_o,
    output logic             swdio_oe
);

    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(1);

    logic             running_q;
    logic             done_q;
    pins_t            pins_q;
    logic [DIV_W-1:0] half_q;
    logic             tick;
    logic             load;
    logic             advance;
    logic             first_bit;
    logic             next_bit;
    logic             is_last;

    assign load    = !running_q && start;
    assign advance = running_q && tick && pins_q.clk_line && !is_last;

    swdlr_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .run   (running_q),
        .limit (half_q),
        .tick  (tick)
    );

    swdlr_bit_source u_bits (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .advance   (advance),
        .first_bit (first_bit),
        .next_bit  (next_bit),
        .is_last   (is_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            done_q    <= 1'b0;
            pins_q    <= PINS_PARKED;
            half_q    <= MIN_HALF;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                running_q      <= 1'b1;
                half_q         <= (div_half == '0) ? MIN_HALF : div_half;
                pins_q.clk_line <= 1'b0;
                pins_q.data     <= first_bit;
                pins_q.data_en  <= 1'b1;
            end else if (running_q && tick) begin
                if (!pins_q.clk_line) begin
                    pins_q.clk_line <= 1'b1;
                end else if (is_last) begin
                    running_q <= 1'b0;
                    done_q    <= 1'b1;
                    pins_q    <= PINS_PARKED;
                end else begin
                    pins_q.clk_line <= 1'b0;
                    pins_q.data     <= next_bit;
                end
            end
        end
    end

    assign busy     = running_q;
    assign done     = done_q;
    assign swclk    = pins_q.clk_line;
    assign swdio_o  = pins_q.data;
    assign swdio_oe = pins_q.data_en;

    // R7
    data_hold_hi_chk: assert property (@(posedge clk) disable iff (rst)
        pins_q.clk_line |-> $stable(pins_q.data));

    // R9
    parked_when_released_chk: assert property (@(posedge clk) disable iff (rst)
        !pins_q.data_en |-> pins_q.clk_line);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9
    done_marks_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!running_q && $past(running_q)));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running_q && !tick) |=> running_q);

endmodule

// File: tb/tb_swd_line_reset_seq.sv
module tb_swd_line_reset_seq;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [DIV_W-1:0] div_half = '0;
    logic             busy, done, swclk, swdio_o, swdio_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic bits [0:255];

    always #5 clk = ~clk;

    swd_line_reset_seq #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .start(start), .div_half(div_half),
        .busy(busy), .done(done), .swclk(swclk),
        .swdio_o(swdio_o), .swdio_oe(swdio_oe)
    );

    function automatic logic exp_bit(input int i);
        logic [15:0] word = 16'hE79E;
        if (i < 64)       return 1'b1;
        else if (i < 80)  return word[i-64];
        else if (i < 144) return 1'b1;
        else              return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic seg_chk(input int lo, input int hi, input string req);
        int bad = 0;
        for (int i = lo; i <= hi; i++) if (bits[i] !== exp_bit(i)) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic run_seq(input int div, input int inject_at, input string tag);
        int h = (div == 0) ? 1 : div;
        int nb = 0, busycyc = 0, runlen = 0, runbad = 0, edgebad = 0, donebad = 0, cyc = 0;
        logic pclk = 1'b1, pdio = 1'b0, poe = 1'b0;
        @(negedge clk);
        start = 1'b1;
        div_half = DIV_W'(div);
        @(negedge clk);
        start = 1'b0;
        div_half = DIV_W'($urandom_range(0, 7));
        // R2 accepted start
        chk(busy && !swclk && swdio_oe, "R2", {busy, swclk, swdio_oe}, 3'b101);
        while (1) begin
            cyc++;
            if (busy) begin
                busycyc++;
                if (cyc > 1 && swclk != pclk) begin
                    if (runlen != h) runbad++;
                    runlen = 0;
                end
                runlen++;
                if (!pclk && swclk) begin
                    if (nb < 256) bits[nb] = swdio_o;
                    nb++;
                end
                if (poe && swdio_oe && swdio_o != pdio && !(pclk && !swclk)) edgebad++;
                if (done) donebad++;
            end else begin
                if (runlen != h) runbad++;
                break;
            end
            pclk = swclk; pdio = swdio_o; poe = swdio_oe;
            if (cyc > 20000) begin
                chk(0, "R8 run did not end", cyc, 304 * h);
                break;
            end
            @(negedge clk);
            start = (cyc == inject_at);
        end
        start = 1'b0;
        seg_chk(0, 63, "R3 lead ones");
        seg_chk(64, 79, "R4 select code LSB first");
        seg_chk(80, 143, "R5 trail ones");
        seg_chk(144, 151, "R6 idle zeros");
        chk(nb == 152, {"R6 R10 bit count ", tag}, nb, 152);
        chk(edgebad == 0, "R7 data change off falling edge", edgebad, 0);
        chk(runbad == 0, "R8 half-period length", runbad, 0);
        chk(busycyc == 304 * h, {"R8 R10 busy length ", tag}, busycyc, 304 * h);
        chk(donebad == 0, "R9 done while busy", donebad, 0);
        chk(done && swclk && !swdio_oe, "R9 end state", {done, swclk, swdio_oe}, 3'b110);
        @(negedge clk);
        chk(!done && !busy, "R9 done single pulse", {done, busy}, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(swclk && !swdio_oe && !swdio_o && !busy && !done, "R1",
            {swclk, swdio_oe, swdio_o, busy, done}, 5'b10000);
        run_seq(1, 0, "div1");
        run_seq(0, 0, "div0");
        run_seq(3, 100, "R10 start while busy");
        run_seq(2, 607, "R10 late start");
        // R11 back-to-back identical runs
        run_seq(2, 0, "R11 first");
        run_seq(2, 0, "R11 second");
        for (int r = 0; r < 4; r++) begin
            int d = $urandom_range(0, 6);
            int hh = (d == 0) ? 1 : d;
            run_seq(d, $urandom_range(1, 304 * hh - 2), "random");
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule